// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns a 64-bit integer register operand into an IEEE-754 floating-point value. The operand can be read as one of four integer types: signed or unsigned, 32-bit or 64-bit. The result can be double precision (binary64) or single precision (binary32). A single-precision result is rounded to binary32 precision and then handed back as the exactly equal binary64 bit pattern, so every result fits a 64-bit floating register. Rounding follows a 2-bit mode field.

The conversion is one combinational path: source selection, leading-zero normalisation, rounding at the target width and packing. A single register stage sits at its end. Each operation presented with `in_valid` produces its result and status one clock later, flagged by `out_valid`.

Alongside the value, the unit reports the following status:
- a 5-bit class code;
- a fraction-rounded bit (magnitude incremented by rounding);
- a fraction-inexact bit;
- sticky-inexact and summary-exception set requests.

These are meaningful only when `stat_upd` is high. A 32-bit source converted to double can never round, so on that path `stat_upd` stays low and the status register file is to be left as it is.

Top module: `i2f_convert`

## Requirements
- R1: `kind` selects the source type: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. The 32-bit types use only `op[31:0]`, so bits 63:32 have no effect on any output.
- R2: With `dbl`=1 and a 32-bit type, the result is the exact binary64 value. `stat_upd` is 0, and `res_class`, `fr`, `fi`, `xx_set` and `fx_set` are all 0.
- R3: With `dbl`=1 and a 64-bit type, the value is rounded to a 53-bit significand using `rm`: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. `stat_upd` is 1.
- R4: With `dbl`=0, for any type, the value is rounded to a 24-bit significand with `rm` and returned as the equal binary64 pattern: binary32 fraction in result bits 51:29, zeros below. `stat_upd` is 1.
- R5: On an updating path, `fr` is 1 exactly when rounding increased the magnitude.
- R6: On an updating path, `fi`, `xx_set` and `fx_set` are 1 exactly when the result differs from the integer value.
- R7: On an updating path, `res_class` is 00100 for a positive normal result and 01000 for a negative normal result.
- R8: An integer zero gives result 0 (positive zero) with flags 0. Its `res_class` is 00010 on updating paths.
- R9: When rounding carries out of the significand, the exponent goes up by one. For example, unsigned 2^64-1 rounded up gives 0x43F0000000000000 in both precisions.
- R10: Outputs register one clock after an `in_valid` cycle, with `out_valid` high for that one cycle. Without `in_valid` the result and status hold their values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid, start a conversion |
| op | input | 64 | Integer source operand |
| kind | input | 2 | Integer source type |
| dbl | input | 1 | 1 = double result, 0 = single result |
| rm | input | 2 | Rounding mode |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Floating result in binary64 layout |
| res_class | output | 5 | Result class code |
| fr | output | 1 | Fraction rounded (magnitude incremented) |
| fi | output | 1 | Fraction inexact |
| xx_set | output | 1 | Request to set the sticky inexact bit |
| fx_set | output | 1 | Request to set the summary exception bit |
| stat_upd | output | 1 | Status outputs are to be written |

## Verification
The assertions assume that `op`, `kind`, `dbl` and `rm` carry known values whenever `in_valid` is high. They also assume every 2-bit code of `kind` and `rm` is legal, so no input combination is excluded. The bench meets this by changing inputs only on the falling edge, and it always drives defined values. The bench sweeps every power of two, its neighbours one above and one below, and their negations. Each of these values is run through every type, both precisions and all four rounding modes. Random operands are added to this sweep, and both are compared against an arithmetic model that rounds by comparing the discarded remainder with one half.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

    typedef enum logic [1:0] {
        KIND_S32 = 2'd0,
        KIND_U32 = 2'd1,
        KIND_S64 = 2'd2,
        KIND_U64 = 2'd3
    } int_kind_e;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TO_ZERO   = 2'd1,
        RND_UP        = 2'd2,
        RND_DOWN      = 2'd3
    } rnd_mode_e;

    localparam logic [4:0] CLS_POS_ZERO   = 5'b00010;
    localparam logic [4:0] CLS_POS_NORMAL = 5'b00100;
    localparam logic [4:0] CLS_NEG_NORMAL = 5'b01000;
    localparam logic [4:0] CLS_NONE       = 5'b00000;

endpackage

// File: rtl/i2f_source.sv
module i2f_source
    import i2f_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op,
    input  int_kind_e       kind,
    output logic            neg,
    output logic [XLEN-1:0] mag
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] widened;

    always_comb begin
        widened = op;
        neg     = 1'b0;
        unique case (kind)
            KIND_S32: begin
                widened = {{HALF{op[HALF-1]}}, op[HALF-1:0]};
                neg     = op[HALF-1];
            end
            KIND_U32: begin
                widened = {{HALF{1'b0}}, op[HALF-1:0]};
            end
            KIND_S64: begin
                widened = op;
                neg     = op[XLEN-1];
            end
            KIND_U64: begin
                widened = op;
            end
        endcase
        mag = neg ? (~widened + 1'b1) : widened;
    end

endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
    parameter int XLEN = 64,
    parameter int LZ_W = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] mag,
    output logic [XLEN-1:0] norm,
    output logic [LZ_W-1:0] lz,
    output logic            is_zero
);
    always_comb begin
        lz = LZ_W'(XLEN);
        for (int i = 0; i < XLEN; i++) begin
            if (mag[i]) lz = LZ_W'(XLEN - 1 - i);
        end
        norm    = mag << lz;
        is_zero = ~|mag;
    end

endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SIG_W = 53
) (
    input  logic [XLEN-1:0]  norm,
    input  logic             neg,
    input  rnd_mode_e        rm,
    output logic [SIG_W-2:0] frac,
    output logic             carry,
    output logic             incr,
    output logic             inexact
);
    localparam int DROP = XLEN - SIG_W;

    logic [SIG_W-1:0] sig;
    logic             guard;
    logic             sticky;
    logic [SIG_W:0]   sum;

    always_comb begin
        sig     = norm[XLEN-1 -: SIG_W];
        guard   = norm[DROP-1];
        sticky  = |norm[DROP-2:0];
        inexact = guard | sticky;
        incr    = 1'b0;
        unique case (rm)
            RND_NEAR_EVEN: incr = guard & (sticky | sig[0]);
            RND_TO_ZERO:   incr = 1'b0;
            RND_UP:        incr = inexact & ~neg;
            RND_DOWN:      incr = inexact & neg;
        endcase
        sum   = {1'b0, sig} + {{SIG_W{1'b0}}, incr};
        carry = sum[SIG_W];
        // after a carry the significand is 1.000..0, one binade higher
        frac  = carry ? sum[SIG_W-1:1] : sum[SIG_W-2:0];
    end

endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
    import i2f_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int EXP_W    = 11,
    parameter int BIAS     = 1023,
    parameter int DP_SIG_W = 53,
    parameter int SP_SIG_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] op,
    input  logic [1:0]      kind,
    input  logic            dbl,
    input  logic [1:0]      rm,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [4:0]      res_class,
    output logic            fr,
    output logic            fi,
    output logic            xx_set,
    output logic            fx_set,
    output logic            stat_upd
);
    localparam int LZ_W   = $clog2(XLEN) + 1;
    localparam int FRAC_W = DP_SIG_W - 1;
    localparam int PAD_W  = DP_SIG_W - SP_SIG_W;

    int_kind_e kind_e;
    rnd_mode_e rm_e;
    assign kind_e = int_kind_e'(kind);
    assign rm_e   = rnd_mode_e'(rm);

    logic            neg;
    logic [XLEN-1:0] mag;
    logic [XLEN-1:0] norm;
    logic [LZ_W-1:0] lz;
    logic            is_zero;

    i2f_source #(.XLEN(XLEN)) u_source (
        .op   (op),
        .kind (kind_e),
        .neg  (neg),
        .mag  (mag)
    );

    i2f_normalize #(.XLEN(XLEN), .LZ_W(LZ_W)) u_norm (
        .mag     (mag),
        .norm    (norm),
        .lz      (lz),
        .is_zero (is_zero)
    );

    logic [DP_SIG_W-2:0] dp_frac;
    logic [SP_SIG_W-2:0] sp_frac;
    logic                dp_carry, sp_carry;
    logic                dp_incr, sp_incr;
    logic                dp_inex, sp_inex;

    i2f_round #(.XLEN(XLEN), .SIG_W(DP_SIG_W)) u_round_dp (
        .norm    (norm),
        .neg     (neg),
        .rm      (rm_e),
        .frac    (dp_frac),
        .carry   (dp_carry),
        .incr    (dp_incr),
        .inexact (dp_inex)
    );

    i2f_round #(.XLEN(XLEN), .SIG_W(SP_SIG_W)) u_round_sp (
        .norm    (norm),
        .neg     (neg),
        .rm      (rm_e),
        .frac    (sp_frac),
        .carry   (sp_carry),
        .incr    (sp_incr),
        .inexact (sp_inex)
    );

    // combinational result
    logic [XLEN-1:0]   res_d;
    logic [4:0]        cls_d;
    logic              fr_d, fi_d, upd_d, carry_sel;
    logic [EXP_W-1:0]  exp_d;
    logic [FRAC_W-1:0] frac_d;

    always_comb begin
        upd_d     = ~dbl | kind[1];
        carry_sel = dbl ? dp_carry : sp_carry;
        frac_d    = dbl ? dp_frac : {sp_frac, {PAD_W{1'b0}}};
        exp_d     = EXP_W'(BIAS) + EXP_W'(XLEN - 1) - EXP_W'(lz)
                  + EXP_W'(carry_sel);
        if (is_zero) begin
            res_d = '0;
            fr_d  = 1'b0;
            fi_d  = 1'b0;
            cls_d = upd_d ? CLS_POS_ZERO : CLS_NONE;
        end else begin
            res_d = {neg, exp_d, frac_d};
            fr_d  = upd_d & (dbl ? dp_incr : sp_incr);
            fi_d  = upd_d & (dbl ? dp_inex : sp_inex);
            cls_d = upd_d ? (neg ? CLS_NEG_NORMAL : CLS_POS_NORMAL) : CLS_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            res_class <= CLS_NONE;
            fr        <= 1'b0;
            fi        <= 1'b0;
            xx_set    <= 1'b0;
            fx_set    <= 1'b0;
            stat_upd  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= res_d;
                res_class <= cls_d;
                fr        <= fr_d;
                fi        <= fi_d;
                xx_set    <= fi_d;
                fx_set    <= fi_d;
                stat_upd  <= upd_d;
            end
        end
    end

    // R5
    fr_needs_fi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr |-> fi);

    // R6
    inexact_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fi |-> (xx_set && fx_set));

    // R2
    quiet_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_upd |-> (!fr && !fi && !xx_set && !fx_set && res_class == CLS_NONE));

    // R7
    class_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_upd |-> $onehot0(res_class[4:1]) && !res_class[0]);

    // R8
    no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result[XLEN-2:0] == '0) |-> !result[XLEN-1]);

    // R10
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && !out_valid));

endmodule

// File: tb/tb_i2f_convert.sv
module tb_i2f_convert;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op = '0;
    logic [1:0]  kind = '0;
    logic        dbl = 1'b0;
    logic [1:0]  rm = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [4:0]  res_class;
    logic        fr, fi, xx_set, fx_set, stat_upd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    i2f_convert dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .kind(kind),
        .dbl(dbl), .rm(rm), .out_valid(out_valid), .result(result),
        .res_class(res_class), .fr(fr), .fi(fi), .xx_set(xx_set),
        .fx_set(fx_set), .stat_upd(stat_upd)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%h kind=%0d dbl=%0d rm=%0d actual=%h expected=%h",
                     tag, op, kind, dbl, rm, act, exp);
        end
    endtask

    // independent model: remainder compared against one half
    function automatic void model(input logic [63:0] a, input logic [1:0] k,
                                  input logic d, input logic [1:0] m,
                                  output logic [63:0] r, output logic [4:0] c,
                                  output logic fr_e, output logic fi_e,
                                  output logic upd_e);
        logic [63:0] v, mg;
        logic        ng, inx, inc;
        logic [64:0] keep, rem, half;
        int          p, pw, sh;
        case (k)
            2'd0: begin v = {{32{a[31]}}, a[31:0]}; ng = a[31]; end
            2'd1: begin v = {32'b0, a[31:0]}; ng = 1'b0; end
            2'd2: begin v = a; ng = a[63]; end
            default: begin v = a; ng = 1'b0; end
        endcase
        mg    = ng ? (~v + 64'd1) : v;
        upd_e = !d || k[1];
        fr_e  = 1'b0;
        fi_e  = 1'b0;
        if (mg == 64'd0) begin
            r = '0;
            c = upd_e ? 5'b00010 : 5'b00000;
            return;
        end
        p = 0;
        for (int i = 0; i < 64; i++) if (mg[i]) p = i;
        pw = d ? 53 : 24;
        if (p >= pw) begin
            sh   = p - pw + 1;
            keep = {1'b0, mg} >> sh;
            rem  = {1'b0, mg} & ((65'd1 << sh) - 65'd1);
            half = 65'd1 << (sh - 1);
        end else begin
            keep = {1'b0, mg} << (pw - 1 - p);
            rem  = '0;
            half = 65'd1;
        end
        inx = (rem != 0);
        case (m)
            2'd0: inc = (rem > half) || (rem == half && keep[0]);
            2'd1: inc = 1'b0;
            2'd2: inc = inx && !ng;
            default: inc = inx && ng;
        endcase
        keep = keep + {64'd0, inc};
        if (keep == (65'd1 << pw)) begin
            keep = keep >> 1;
            p    = p + 1;
        end
        r    = {ng, 11'(p + 1023), d ? keep[51:0] : {keep[22:0], 29'b0}};
        c    = upd_e ? (ng ? 5'b01000 : 5'b00100) : 5'b00000;
        fr_e = upd_e && inc;
        fi_e = upd_e && inx;
    endfunction

    task automatic apply(input logic [63:0] a, input logic [1:0] k,
                         input logic d, input logic [1:0] m);
        @(negedge clk);
        op = a; kind = k; dbl = d; rm = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_vec(input logic [63:0] a, input logic [1:0] k,
                           input logic d, input logic [1:0] m);
        logic [63:0] er;
        logic [4:0]  ec;
        logic        efr, efi, eup;
        model(a, k, d, m, er, ec, efr, efi, eup);
        apply(a, k, d, m);
        check("R10 out_valid", 64'(out_valid), 64'd1);
        if (d && !k[1])  check("R2 exact double", result, er);
        else if (d)      check("R3 rounded double", result, er);
        else             check("R4 rounded single", result, er);
        check("R2 stat_upd", 64'(stat_upd), 64'(eup));
        check("R7 class", 64'(res_class), 64'(ec));
        check("R5 fr", 64'(fr), 64'(efr));
        check("R6 fi", 64'(fi), 64'(efi));
        check("R6 xx/fx", {62'd0, xx_set, fx_set}, {62'd0, efi, efi});
        if (a == 64'd0) check("R8 zero", result, 64'd0);
    endtask

    initial begin
        logic [63:0] lfsr;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // reset state
        check("R10 reset valid", 64'(out_valid), 64'd0);
        check("R10 reset result", result, 64'd0);
        check("R10 reset class", 64'(res_class), 64'd0);
        rst_n = 1'b1;

        // R1: upper bits ignored for 32-bit types
        apply(64'hDEADBEEF_00000005, 2'd1, 1'b1, 2'd0);
        check("R1 u32 upper ignored", result, 64'h4014000000000000);
        apply(64'h12345678_FFFFFFFF, 2'd0, 1'b1, 2'd0);
        check("R1 s32 upper ignored", result, 64'hBFF0000000000000);
        apply(64'hFFFFFFFF_00000000, 2'd0, 1'b0, 2'd2);
        check("R1 upper ignored zero", result, 64'd0);
        check("R8 zero class", 64'(res_class), 64'h02);

        // R9: carry out of the significand
        apply(64'hFFFFFFFF_FFFFFFFF, 2'd3, 1'b1, 2'd0);
        check("R9 u64 max double rne", result, 64'h43F0000000000000);
        apply(64'hFFFFFFFF_FFFFFFFF, 2'd3, 1'b0, 2'd2);
        check("R9 u64 max single up", result, 64'h43F0000000000000);
        apply(64'hFFFFFFFF_FFFFFFFF, 2'd3, 1'b0, 2'd1);
        check("R9 u64 max single rz", result, 64'h43EFFFFFE0000000);

        // R10: hold while idle
        held = result;
        @(negedge clk);
        op = 64'h1234; kind = 2'd2; dbl = 1'b1;
        @(negedge clk);
        check("R10 hold result", result, held);
        check("R10 idle valid", 64'(out_valid), 64'd0);

        // sweep around every power of two
        for (int b = 0; b < 64; b++) begin
            for (int vsel = 0; vsel < 6; vsel++) begin
                logic [63:0] base;
                base = 64'd1 << b;
                case (vsel % 3)
                    0: base = base;
                    1: base = base - 64'd1;
                    default: base = base + 64'd1;
                endcase
                if (vsel >= 3) base = ~base + 64'd1;
                for (int k = 0; k < 4; k++)
                    for (int d = 0; d < 2; d++)
                        for (int m = 0; m < 4; m++)
                            run_vec(base, 2'(k), 1'(d), 2'(m));
            end
        end

        // random operands
        lfsr = 64'hACE1_2468_9BDF_1357;
        for (int n = 0; n < 1500; n++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            run_vec(lfsr, lfsr[1:0], lfsr[7], lfsr[13:12]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule